// File: doc/BRIEF.md
# Interrupt and Output Pin Controller

This block holds a small configuration word that software loads through a single-cycle register write and reads back through a read port. The word decides how an internal interrupt-pending level is shown on the interrupt pin. The pin can be an active-low level, an active-high level, a single-clock low pulse on an idle-high pin, or a single-clock high pulse on an idle-low pin.

The same word controls two general output pins, energy-out and direction. Normally they follow their internal sources, which arrive as plain inputs. Software can instead force them to fixed data bits. It can also put both pins into an open-drain style, so that the pins of several devices can share a wire with an external pull-up. Each output pin is modelled as a data value plus an output enable.

Writing the self-clearing reset bit starts an internal reset pulse of fixed length. The pulse returns every configuration field to its default.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After the reset input, the read port returns 0. The interrupt pin is high while pending is low. The energy-out and direction pins follow their sources with both output enables at 1. The internal reset output is low.
- R2: In interrupt mode 0 (field bits [5:4] = 2'b00), the interrupt pin is the inverse of the pending input.
- R3: In interrupt mode 1 (bits [5:4] = 2'b01), the interrupt pin equals the pending input.
- R4: In interrupt mode 2 (bits [5:4] = 2'b10), the pin idles high. In the cycle after pending rises, the pin goes low for exactly one clock. It stays high while pending is held, and pulses again only after pending falls and rises.
- R5: In interrupt mode 3 (bits [5:4] = 2'b11), the pin idles low. After each new rise of pending, the pin goes high for exactly one clock.
- R6: With the override bit (bit 3) at 0, energy-out follows its source input and direction follows its source input.
- R7: With the override bit at 1, direction takes bit 1 and energy-out takes bit 2 of the stored word.
- R8: With the wire-AND bit (bit 6) at 1, both pin data outputs are 0 and each output enable is the inverse of that pin's logical value. With bit 6 at 0, both enables are 1 and the data outputs carry the logical value.
- R9: Bit 7 is reserved and bit 0 is the reset bit. Both always read 0, and a value written to bit 7 has no effect.
- R10: A write with bit 0 set drives the internal reset output high for exactly RST_PULSE clocks, starting in the cycle after the write. It returns the word to all defaults, and writes made during the pulse are ignored.
- R11: A write with bit 0 clear loads bits 6..1 in one cycle, and the read port shows them in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 8 | Configuration word to write |
| rd_data | output | 8 | Stored configuration word |
| irq_pend | input | 1 | Internal interrupt-pending level |
| eout_src | input | 1 | Normal source of the energy-out pin |
| dir_src | input | 1 | Normal source of the direction pin |
| irq_o | output | 1 | Interrupt pin |
| eout_o | output | 1 | Energy-out pin data |
| eout_oe | output | 1 | Energy-out pin output enable |
| dir_o | output | 1 | Direction pin data |
| dir_oe | output | 1 | Direction pin output enable |
| int_rst | output | 1 | Internal reset pulse |

## Verification
The bench builds the block with the default RST_PULSE of 8. The whole pulse is counted cycle by cycle, so the exact length and the bound below ten clocks are both checked. A short pulse also leaves room to try a write in the middle of it and see that the write is dropped. Each edge mode is driven with pending held for several cycles, then dropped and raised again. This exposes both a repeated pulse and a missing re-arm.

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl #(
  parameter int RST_PULSE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       irq_pend,
  input  logic       eout_src,
  input  logic       dir_src,
  output logic       irq_o,
  output logic       eout_o,
  output logic       eout_oe,
  output logic       dir_o,
  output logic       dir_oe,
  output logic       int_rst
);
  localparam int CW = $clog2(RST_PULSE + 1);

  logic [5:0]    cfg_q;
  logic [CW-1:0] cnt_q;
  logic          pend_q, edge_q;

  wire       dir_val  = cfg_q[0];
  wire       eout_val = cfg_q[1];
  wire       ovr_en   = cfg_q[2];
  wire [1:0] mode     = cfg_q[4:3];
  wire       wand_en  = cfg_q[5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      cfg_q <= '0;
    end else if (wr_en) begin
      if (wr_data[0]) begin
        cnt_q <= CW'(RST_PULSE);
        cfg_q <= '0;
      end else begin
        cfg_q <= wr_data[6:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      pend_q <= irq_pend;
      edge_q <= irq_pend & ~pend_q;
    end
  end

  always_comb begin
    case (mode)
      2'b00:   irq_o = ~irq_pend;
      2'b01:   irq_o = irq_pend;
      2'b10:   irq_o = ~edge_q;
      default: irq_o = edge_q;
    endcase
  end

  wire eout_v = ovr_en ? eout_val : eout_src;
  wire dir_v  = ovr_en ? dir_val  : dir_src;

  assign eout_o  = wand_en ? 1'b0 : eout_v;
  assign eout_oe = wand_en ? ~eout_v : 1'b1;
  assign dir_o   = wand_en ? 1'b0 : dir_v;
  assign dir_oe  = wand_en ? ~dir_v : 1'b1;

  assign int_rst = (cnt_q != '0);
  assign rd_data = {1'b0, cfg_q, 1'b0};
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk #(
  parameter int RST_PULSE = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] rd_data,
  input logic       irq_pend,
  input logic       irq_o,
  input logic       eout_o,
  input logic       eout_oe,
  input logic       dir_o,
  input logic       dir_oe,
  input logic       int_rst
);
  localparam int W = $clog2(RST_PULSE + 2);
  logic [W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= int_rst ? run_q + 1'b1 : '0;
  end

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == 1'b0 && rd_data[0] == 1'b0);

  p_level_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:4] == 2'b00 |-> irq_o == !irq_pend);

  p_level_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:4] == 2'b01 |-> irq_o == irq_pend);

  p_rise_one_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5:4] == 2'b11 && irq_o && !wr_en && !int_rst) |=> !irq_o);

  p_fall_one_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5:4] == 2'b10 && !irq_o && !wr_en && !int_rst) |=> irq_o);

  p_wand_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6] |-> (!eout_o && !dir_o));

  p_push_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[6] |-> (eout_oe && dir_oe));

  p_pulse_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> rd_data == 8'h00);

  p_pulse_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |-> run_q < W'(RST_PULSE));

  p_pulse_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst) |-> run_q == W'(RST_PULSE));
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk #(.RST_PULSE(RST_PULSE)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_data(rd_data),
  .irq_pend(irq_pend), .irq_o(irq_o), .eout_o(eout_o), .eout_oe(eout_oe),
  .dir_o(dir_o), .dir_oe(dir_oe), .int_rst(int_rst)
);

// File: tb/test_irq_pin_ctrl.sv
module test_irq_pin_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic irq_pend = 1'b0, eout_src = 1'b0, dir_src = 1'b0;
  logic [7:0] rd_data;
  logic irq_o, eout_o, eout_oe, dir_o, dir_oe, int_rst;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_pin_ctrl #(.RST_PULSE(8)) i_irq_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_pend(irq_pend), .eout_src(eout_src), .dir_src(dir_src), .irq_o(irq_o),
    .eout_o(eout_o), .eout_oe(eout_oe), .dir_o(dir_o), .dir_oe(dir_oe), .int_rst(int_rst)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h01);
    chk("R1 oe", {6'b0, eout_oe, dir_oe}, 8'h03);
    chk("R1 rst", {7'b0, int_rst}, 8'h00);
    eout_src = 1'b1; dir_src = 1'b0; #1;
    chk("R1 pins", {6'b0, eout_o, dir_o}, 8'h02);
  endtask

  task automatic t_levels;
    wr(8'h00);
    irq_pend = 1'b1; #1; chk("R2 pend1", {7'b0, irq_o}, 8'h00);
    irq_pend = 1'b0; #1; chk("R2 pend0", {7'b0, irq_o}, 8'h01);
    wr(8'h10);
    chk("R11 load", rd_data, 8'h10);
    chk("R3 pend0", {7'b0, irq_o}, 8'h00);
    irq_pend = 1'b1; #1; chk("R3 pend1", {7'b0, irq_o}, 8'h01);
    irq_pend = 1'b0; #1;
  endtask

  task automatic t_edge(input logic [7:0] word, input logic idle, input string req);
    wr(word);
    chk({req, " idle"}, {7'b0, irq_o}, {7'b0, idle});
    for (int rep = 0; rep < 2; rep++) begin
      @(negedge clk); irq_pend = 1'b1;
      @(negedge clk); chk({req, " pulse"}, {7'b0, irq_o}, {7'b0, ~idle});
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); chk({req, " held"}, {7'b0, irq_o}, {7'b0, idle});
      end
      irq_pend = 1'b0;
      @(negedge clk); chk({req, " low"}, {7'b0, irq_o}, {7'b0, idle});
    end
  endtask

  task automatic t_outputs;
    wr(8'h00);
    eout_src = 1'b0; dir_src = 1'b1; #1;
    chk("R6 follow", {6'b0, eout_o, dir_o}, 8'h01);
    eout_src = 1'b1; dir_src = 1'b0; #1;
    chk("R6 follow2", {6'b0, eout_o, dir_o}, 8'h02);
    wr(8'h0A);
    chk("R7 ovr dir", {6'b0, eout_o, dir_o}, 8'h01);
    wr(8'h0C);
    chk("R7 ovr eout", {6'b0, eout_o, dir_o}, 8'h02);
    wr(8'h4C);
    chk("R8 wand data", {6'b0, eout_o, dir_o}, 8'h00);
    chk("R8 wand oe", {6'b0, eout_oe, dir_oe}, 8'h01);
    wr(8'h40);
    eout_src = 1'b0; dir_src = 1'b1; #1;
    chk("R8 wand src oe", {6'b0, eout_oe, dir_oe}, 8'h02);
    chk("R8 wand src data", {6'b0, eout_o, dir_o}, 8'h00);
  endtask

  task automatic t_reserved;
    wr(8'h80);
    chk("R9 rsvd", rd_data, 8'h00);
    wr(8'hFE);
    chk("R9 rsvd hi", rd_data, 8'h7E);
    chk("R9 pins", {6'b0, eout_o, dir_o}, 8'h00);
  endtask

  task automatic t_softrst;
    int n;
    wr(8'h7E);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h01;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R10 start", {7'b0, int_rst}, 8'h01);
    chk("R10 cleared", rd_data, 8'h00);
    n = 1;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h0E; n++;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    while (int_rst && n < 20) begin
      n++;
      @(negedge clk);
    end
    chk("R10 length", 8'(n), 8'd8);
    chk("R10 ignored", rd_data, 8'h00);
    chk("R9 rbit", {7'b0, rd_data[0]}, 8'h00);
  endtask

  initial begin
    #5000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_edge(8'h20, 1'b1, "R4");
    t_edge(8'h30, 1'b0, "R5");
    t_outputs();
    t_reserved();
    t_softrst();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule